// File: doc/BRIEF.md
# LFSR Terminal-Count Clock Divider

This block divides a fast clock by a fixed even ratio. It does not use a binary counter. A 14-bit linear feedback shift register steps once per input clock through a maximal-length pseudo-random sequence. When the register reaches a terminal word, it reloads its starting word and flips the divided output. The starting word is a hex constant. The terminal word is derived at elaboration as the state exactly one half-period minus one shift after the start. The loop is therefore fixed by where the two words sit in the sequence, and there is no numeric compare against a count.

With the default constants the output flips every 12499 input clocks, so the full division ratio is 24998 with a 50 % duty cycle. Reset is active low and acts on both the shift register and the output together. The output is therefore low for the whole time reset is held, and it does not follow reset one cycle late.

Top module: `lfsr_clk_div`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is low, and it goes low as soon as reset is asserted, without waiting for a clock edge.
- R2: After reset is released, the first rising edge of `clk_o` follows the 12499th rising edge of `clk_i`.
- R3: After that, `clk_o` changes level on every 12499th rising edge of `clk_i` and holds its level on all other edges, giving a full output period of 24998 input clocks.
- R4: The high phase and the low phase of `clk_o` are both exactly 12499 input clocks long.
- R5: The shift register never holds the all-ones word. All-ones is the lock-up word of the inverted-XOR feedback, and the start word 14'h1A5C is not all-ones.
- R6: On the clock after the register holds the terminal word, it holds the start word again.
- R7: If reset is asserted in the middle of an output phase and then released, the sequence restarts. The output is low, and its next rise follows the 12499th input edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low reset for the shift register and the output |
| clk_o | output | 1 | Divided clock, starts low after reset |

## Verification
Any error in the feedback taps, the inversion, the start word or the terminal word changes where the terminal word falls in the sequence, or stops the register from ever reaching it. At the output this shows as a first edge that comes at the wrong input-edge count. That difference is visible within the first half-period of 12499 clocks. A register stuck at its lock-up word freezes `clk_o` for good. A reload fault or a toggle fault makes the phases unequal, and this shows in the very next interval measured between two output edges.

// File: rtl/lfsr_clk_div_pkg.sv
package lfsr_clk_div_pkg;

  localparam int unsigned LFSR_W = 14;
  // taps at stages 14, 13, 12, 2 (bits 13, 12, 11, 1)
  localparam logic [LFSR_W-1:0] TAPS_DEF = 14'h3802;
  localparam logic [LFSR_W-1:0] SEED_DEF = 14'h1A5C;
  localparam int unsigned HALF_DEF = 12499;

  typedef logic [LFSR_W-1:0] state_t;
  typedef logic [LFSR_W:0] row_t;
  typedef logic [LFSR_W:0][LFSR_W:0] amat_t;

  // one step, written as inverted parity so the inversion count is explicit
  function automatic state_t lfsr_step(state_t s, state_t taps);
    logic fb;
    fb = ~(^(s & taps));
    return {s[LFSR_W-2:0], fb};
  endfunction

  function automatic amat_t amat_mul(amat_t a, amat_t b);
    amat_t c;
    for (int i = 0; i <= LFSR_W; i++) begin
      c[i] = '0;
      for (int j = 0; j <= LFSR_W; j++) begin
        if (a[i][j]) c[i] = c[i] ^ b[j];
      end
    end
    return c;
  endfunction

  // affine step matrix; bit LFSR_W of the vector is the constant one
  function automatic amat_t step_matrix(state_t taps);
    amat_t m;
    m[0] = {1'b1, taps};
    for (int i = 1; i < LFSR_W; i++) m[i] = row_t'(1) << (i - 1);
    m[LFSR_W] = row_t'(1) << LFSR_W;
    return m;
  endfunction

  // state reached n steps after s, by matrix squaring
  function automatic state_t lfsr_jump(state_t s, state_t taps, int unsigned n);
    amat_t  acc;
    amat_t  pw;
    row_t   v;
    state_t r;
    for (int i = 0; i <= LFSR_W; i++) acc[i] = row_t'(1) << i;
    pw = step_matrix(taps);
    for (int b = 0; b < 32; b++) begin
      if (n[b]) acc = amat_mul(acc, pw);
      pw = amat_mul(pw, pw);
    end
    v = {1'b1, s};
    for (int i = 0; i < LFSR_W; i++) r[i] = ^(acc[i] & v);
    return r;
  endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
  import lfsr_clk_div_pkg::*;
#(
  parameter state_t TAPS = TAPS_DEF
) (
  input  state_t cur_i,
  output state_t nxt_o
);
  always_comb nxt_o = lfsr_step(cur_i, TAPS);
endmodule

// File: rtl/lfsr_seq.sv
module lfsr_seq
  import lfsr_clk_div_pkg::*;
#(
  parameter state_t TAPS = TAPS_DEF,
  parameter state_t SEED = SEED_DEF,
  parameter state_t TERM = SEED_DEF
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output state_t state_o,
  output logic   wrap_o
);
  state_t state_q;
  state_t step_d;

  lfsr_feedback #(.TAPS(TAPS)) u_fb (
    .cur_i(state_q),
    .nxt_o(step_d)
  );

  assign wrap_o = (state_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (wrap_o) state_q <= SEED;
    else             state_q <= step_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/div_toggle.sv
module div_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic q_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) q_q <= ~q_q;
  end
  assign q_o = q_q;
endmodule

// File: rtl/lfsr_clk_div.sv
module lfsr_clk_div
  import lfsr_clk_div_pkg::*;
#(
  parameter state_t      TAPS        = TAPS_DEF,
  parameter state_t      SEED        = SEED_DEF,
  parameter int unsigned HALF_PERIOD = HALF_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  localparam state_t TERM = lfsr_jump(SEED, TAPS, HALF_PERIOD - 1);

  state_t lfsr_q;
  logic   wrap;

  lfsr_seq #(.TAPS(TAPS), .SEED(SEED), .TERM(TERM)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(lfsr_q),
    .wrap_o (wrap)
  );

  div_toggle u_tgl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (wrap),
    .q_o   (clk_o)
  );
endmodule

// File: rtl/lfsr_clk_div_chk.sv
module lfsr_clk_div_chk
  import lfsr_clk_div_pkg::*;
#(
  parameter state_t      TAPS = TAPS_DEF,
  parameter state_t      SEED = SEED_DEF,
  parameter int unsigned HALF = HALF_DEF
) (
  input logic   clk_i,
  input logic   rst_ni,
  input logic   clk_o,
  input state_t state_i
);
  localparam state_t      TERM = lfsr_jump(SEED, TAPS, HALF - 1);
  localparam int unsigned CW   = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  // edges since release, modulo the half period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == CW'(HALF - 1)) ? '0 : cnt_q + 1'b1;
      run_q <= 1'b1;
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk_i) !rst_ni |-> !clk_o); // R1

  AST_NO_LOCKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != '1); // R5

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == TERM |=> state_i == SEED); // R6

  AST_TOGGLE_AT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == '0) |-> clk_o != $past(clk_o)); // R3

  AST_HOLD_ELSEWHERE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |-> $stable(clk_o)); // R4
endmodule

bind lfsr_clk_div lfsr_clk_div_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clk_o  (clk_o),
  .state_i(lfsr_q)
);

// File: tb/lfsr_clk_div_tb.sv
module lfsr_clk_div_tb;
  localparam int unsigned HALF   = 12499;
  localparam int unsigned NTGL   = 8;
  localparam int unsigned WDOG   = 190000;
  // expected edge count and level after each output change
  localparam int unsigned EXP_EDGE [NTGL] = '{12499, 24998, 37497, 49996,
                                              62495, 74994, 87493, 99992};
  localparam logic        EXP_LVL  [NTGL] = '{1'b1, 1'b0, 1'b1, 1'b0,
                                              1'b1, 1'b0, 1'b1, 1'b0};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned edge_cnt = 0;
  int unsigned cyc = 0;

  lfsr_clk_div u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clk_o (clk_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (!rst_ni) edge_cnt <= 0;
    else         edge_cnt <= edge_cnt + 1;
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // wait at falling edges until clk_o changes level
  task automatic wait_change(output int unsigned at, output logic lvl);
    logic prev;
    prev = clk_o;
    for (int k = 0; k < HALF + 100; k++) begin
      @(negedge clk_i);
      if (clk_o !== prev) begin
        at  = edge_cnt;
        lvl = clk_o;
        return;
      end
    end
    at  = 0;
    lvl = prev;
  endtask

  always @(negedge clk_i) begin
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    int unsigned at;
    logic        lvl;
    repeat (5) @(negedge clk_i);
    check("R1 reset level", clk_o, 0);
    rst_ni = 1'b1;

    // R2 first edge, R3/R4 following intervals
    for (int i = 0; i < NTGL; i++) begin
      wait_change(at, lvl);
      check(i == 0 ? "R2 first rise edge" : "R3 toggle edge", at, EXP_EDGE[i]);
      check("R4 phase level", lvl, EXP_LVL[i]);
    end

    // R1 mid-phase reset: wait for a high phase, drop reset between edges
    wait_change(at, lvl);
    check("R3 toggle edge", at, 9 * HALF);
    check("R4 phase level", lvl, 1);
    repeat (100) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1 check("R1 async low", clk_o, 0);
    repeat (3) @(negedge clk_i);
    check("R1 held low", clk_o, 0);
    rst_ni = 1'b1;

    // R7 restart after release
    wait_change(at, lvl);
    check("R7 restart rise edge", at, HALF);
    check("R7 restart level", lvl, 1);
    wait_change(at, lvl);
    check("R7 restart second edge", at, 2 * HALF);
    finish_run();
  end
endmodule